// File: doc/BRIEF.md
# Adaptive Edge Threshold Controller

This block holds one edge-threshold weight for every macro-block position of a small frame. The weight is a fraction between 0 and 1. It sets where the edge threshold sits between the smallest and the largest gradient of that macro-block. Each time a macro-block's combined sampling mask has been built, the block receives the number of active pixels in that mask. It then moves that macro-block's weight toward the value that would have produced the target count. The new weight is used the next time the same position comes round, which is one frame later.

The step is proportional. The count error (achieved minus target) is first divided by the pixel count of a macro-block (256). It is then multiplied by a host-supplied gain and added to the stored weight, and the sum is clamped to the range 0 to 1. Lowering the target reduces the switching activity of the matching array, so the host sets the target and the gain from its power policy. A separate registered read port returns the weight of any macro-block one cycle after it is addressed.

Top module: `edge_thr_adapt`

## Requirements
- R1: After reset every stored weight equals mid-scale. Weights are unsigned fixed point with 8 fraction bits (value 256 means 1.0), so mid-scale is 128.
- R2: On a cycle with `upd_valid` high, the weight of entry `upd_mb` becomes cur + floor(kp_gain × (upd_cnt − tgt_cnt) / 256). Here `kp_gain` is an unsigned gain with 8 fraction bits and floor rounds toward minus infinity. The clamp of R3 and R4 then applies.
- R3: An updated weight whose sum is below 0 is stored as 0.
- R4: An updated weight whose sum is above 256 (1.0) is stored as 256.
- R5: An update changes only the addressed entry; all other entries keep their values.
- R6: `rd_thr` presents the weight of the entry addressed by `rd_mb` one clock after it is addressed. When the same entry is updated on that same edge, the value returned is the weight from before the update.
- R7: While `upd_valid` is low, no stored weight changes, whatever the values on `upd_cnt`, `tgt_cnt` and `kp_gain`.
- R8: An update whose achieved count equals the target leaves the entry unchanged for any gain.
- R9: The extreme inputs (gain 255, count error +256 or −256) do not overflow the arithmetic and still saturate at 256 or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Apply one update this cycle |
| upd_mb | input | 4 | Macro-block index to update (row-major) |
| upd_cnt | input | 9 | Active pixels achieved in that macro-block's mask (0..256) |
| tgt_cnt | input | 9 | Target active pixel count chosen by the host |
| kp_gain | input | 8 | Loop gain, unsigned, 8 fraction bits |
| rd_mb | input | 4 | Macro-block index to read |
| rd_thr | output | 9 | Registered weight of the read entry, 8 fraction bits |

## Verification
A corrupted weight in this block does not show up at once. It appears at `rd_thr` only when the faulty entry is read, one cycle after it is addressed. After that it is carried forward into every later update of the same macro-block, so a wrong clamp or a sign error grows frame after frame. A write that lands on the wrong index is visible only through a neighbour's weight, so the bench reads back the neighbours of each updated entry. The same-edge read and update case separates a read that takes the old value from one that forwards the new value, with a difference of exactly one cycle.

// File: rtl/edge_thr_pkg.sv
package edge_thr_pkg;

    // Classification of one update step, reported by the step unit.
    typedef enum logic [2:0] {
        STEP_HOLD   = 3'd0,
        STEP_RAISE  = 3'd1,
        STEP_LOWER  = 3'd2,
        STEP_SAT_HI = 3'd3,
        STEP_SAT_LO = 3'd4
    } step_kind_e;

endpackage

// File: rtl/mb_wr_decode.sv
module mb_wr_decode #(
    parameter int unsigned NUM_MB = 16,
    localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [NUM_MB-1:0] wr_sel
);

    // One write strobe per stored entry.
    for (genvar g = 0; g < NUM_MB; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

endmodule

// File: rtl/mb_step_calc.sv
module mb_step_calc
    import edge_thr_pkg::*;
#(
    parameter int unsigned FRAC_W  = 8,
    parameter int unsigned GAIN_W  = 8,
    parameter int unsigned BLK_PIX = 256,
    localparam int unsigned CNT_W  = $clog2(BLK_PIX + 1),
    localparam int unsigned PAR_W  = FRAC_W + 1,
    localparam int unsigned NORM_W = $clog2(BLK_PIX),
    localparam int unsigned SHIFT  = GAIN_W + NORM_W - FRAC_W,
    localparam int unsigned DIF_W  = CNT_W + 1,
    localparam int unsigned PRD_W  = DIF_W + GAIN_W + 1,
    localparam int unsigned SUM_W  = ((PRD_W > PAR_W + 1) ? PRD_W : PAR_W + 1) + 1,
    localparam int unsigned ONE    = 1 << FRAC_W
) (
    input  logic [PAR_W-1:0]  cur_thr,
    input  logic [CNT_W-1:0]  got_cnt,
    input  logic [CNT_W-1:0]  want_cnt,
    input  logic [GAIN_W-1:0] gain,
    output logic [PAR_W-1:0]  nxt_thr,
    output step_kind_e        kind
);

    logic signed [DIF_W-1:0] err;
    logic signed [PRD_W-1:0] prod;
    logic signed [PRD_W-1:0] step;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        // Signed, widened count error: no wrap for any pair of counts.
        err  = $signed({1'b0, got_cnt}) - $signed({1'b0, want_cnt});
        prod = PRD_W'(err) * $signed({{(PRD_W-GAIN_W){1'b0}}, gain});
        // Gain fraction and per-block normalisation, minus the weight's own fraction.
        step = prod >>> SHIFT;
        sum  = SUM_W'(step) + $signed({{(SUM_W-PAR_W){1'b0}}, cur_thr});

        if (sum < 0) begin
            nxt_thr = '0;
            kind    = STEP_SAT_LO;
        end else if (sum > $signed(SUM_W'(ONE))) begin
            nxt_thr = PAR_W'(ONE);
            kind    = STEP_SAT_HI;
        end else begin
            nxt_thr = sum[PAR_W-1:0];
            if (step > 0)      kind = STEP_RAISE;
            else if (step < 0) kind = STEP_LOWER;
            else               kind = STEP_HOLD;
        end
    end

endmodule

// File: rtl/mb_param_bank.sv
module mb_param_bank #(
    parameter int unsigned NUM_MB = 16,
    parameter int unsigned PAR_W  = 9,
    parameter int unsigned INIT   = 128,
    localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MB-1:0] wr_sel,
    input  logic [PAR_W-1:0]  wr_val,
    input  logic [IDX_W-1:0]  cur_idx,
    output logic [PAR_W-1:0]  cur_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PAR_W-1:0]  rd_val
);

    typedef struct packed {
        logic [NUM_MB-1:0][PAR_W-1:0] ent;
        logic [PAR_W-1:0]             rd;
    } bank_s;

    bank_s st_d, st_q;

    // Update path sees the stored value combinationally.
    assign cur_val = st_q.ent[cur_idx];
    assign rd_val  = st_q.rd;

    always_comb begin
        st_d = st_q;
        // Read samples the pre-update contents.
        st_d.rd = st_q.ent[rd_idx];
        for (int i = 0; i < NUM_MB; i++) begin
            if (wr_sel[i]) st_d.ent[i] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MB; i++) st_q.ent[i] <= PAR_W'(INIT);
            st_q.rd <= PAR_W'(INIT);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/edge_thr_adapt.sv
module edge_thr_adapt
    import edge_thr_pkg::*;
#(
    parameter int unsigned MB_COLS = 4,
    parameter int unsigned MB_ROWS = 4,
    parameter int unsigned BLK_PIX = 256,
    parameter int unsigned FRAC_W  = 8,
    parameter int unsigned GAIN_W  = 8,
    localparam int unsigned NUM_MB = MB_COLS * MB_ROWS,
    localparam int unsigned IDX_W  = $clog2(NUM_MB),
    localparam int unsigned CNT_W  = $clog2(BLK_PIX + 1),
    localparam int unsigned PAR_W  = FRAC_W + 1,
    localparam int unsigned HALF   = 1 << (FRAC_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_mb,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic [CNT_W-1:0]  tgt_cnt,
    input  logic [GAIN_W-1:0] kp_gain,
    input  logic [IDX_W-1:0]  rd_mb,
    output logic [PAR_W-1:0]  rd_thr
);

    logic [NUM_MB-1:0] wr_sel;
    logic [PAR_W-1:0]  cur_thr;
    logic [PAR_W-1:0]  nxt_thr;
    step_kind_e        step_kind;

    mb_wr_decode #(.NUM_MB(NUM_MB)) u_dec (
        .wr_en  (upd_valid),
        .wr_idx (upd_mb),
        .wr_sel (wr_sel)
    );

    mb_step_calc #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .BLK_PIX(BLK_PIX)) u_step (
        .cur_thr  (cur_thr),
        .got_cnt  (upd_cnt),
        .want_cnt (tgt_cnt),
        .gain     (kp_gain),
        .nxt_thr  (nxt_thr),
        .kind     (step_kind)
    );

    mb_param_bank #(.NUM_MB(NUM_MB), .PAR_W(PAR_W), .INIT(HALF)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_val  (nxt_thr),
        .cur_idx (upd_mb),
        .cur_val (cur_thr),
        .rd_idx  (rd_mb),
        .rd_val  (rd_thr)
    );

endmodule

// File: rtl/edge_thr_adapt_chk.sv
module edge_thr_adapt_chk
    import edge_thr_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 9,
    parameter int unsigned PAR_W = 9,
    parameter int unsigned ONE   = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic [CNT_W-1:0] upd_cnt,
    input logic [CNT_W-1:0] tgt_cnt,
    input logic [PAR_W-1:0] cur_thr,
    input logic [PAR_W-1:0] nxt_thr,
    input step_kind_e       step_kind,
    input logic [IDX_W-1:0] rd_mb,
    input logic [PAR_W-1:0] rd_thr
);

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2) age_q <= age_q + 2'd1;
    end

    // R3
    rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_thr <= PAR_W'(ONE));

    // R4
    sat_hi_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && step_kind == STEP_SAT_HI |-> nxt_thr == PAR_W'(ONE));

    // R3
    sat_lo_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && step_kind == STEP_SAT_LO |-> nxt_thr == '0);

    // R8
    equal_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_cnt == tgt_cnt |-> nxt_thr == cur_thr);

    // R2
    raise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_cnt > tgt_cnt |-> nxt_thr >= cur_thr);

    // R2
    lower_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_cnt < tgt_cnt |-> nxt_thr <= cur_thr);

    // R7
    idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_q == 2 && !$past(upd_valid) && rd_mb == $past(rd_mb) |=> $stable(rd_thr));

endmodule

bind edge_thr_adapt edge_thr_adapt_chk #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .PAR_W(PAR_W), .ONE(1 << FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_cnt   (upd_cnt),
    .tgt_cnt   (tgt_cnt),
    .cur_thr   (cur_thr),
    .nxt_thr   (nxt_thr),
    .step_kind (step_kind),
    .rd_mb     (rd_mb),
    .rd_thr    (rd_thr)
);

// File: tb/tb_edge_thr_adapt.sv
`timescale 1ns/1ps
module tb_edge_thr_adapt;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_valid = 1'b0;
    logic [3:0] upd_mb = '0;
    logic [8:0] upd_cnt = '0;
    logic [8:0] tgt_cnt = '0;
    logic [7:0] kp_gain = '0;
    logic [3:0] rd_mb = '0;
    logic [8:0] rd_thr;

    int n_run = 0;
    int n_fail = 0;
    int model [16];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_thr_adapt dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_mb(upd_mb),
        .upd_cnt(upd_cnt), .tgt_cnt(tgt_cnt), .kp_gain(kp_gain),
        .rd_mb(rd_mb), .rd_thr(rd_thr)
    );

    function automatic int step_model(int cur, int cnt, int tgt, int g);
        int p = g * (cnt - tgt);
        int v = cur + (p >>> 8);
        if (v < 0)   v = 0;
        if (v > 256) v = 256;
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_mb(int idx, output int val);
        @(negedge clk);
        rd_mb = 4'(idx);
        @(negedge clk);
        val = int'(rd_thr);
    endtask

    task automatic update(int idx, int cnt, int tgt, int g);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_mb = 4'(idx);
        upd_cnt = 9'(cnt);
        tgt_cnt = 9'(tgt);
        kp_gain = 8'(g);
        model[idx] = step_model(model[idx], cnt, tgt, g);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic check_all(string req);
        int v;
        for (int i = 0; i < 16; i++) begin
            read_mb(i, v);
            check(req, v, model[i]);
        end
    endtask

    task automatic t_reset;
        // R1: all entries at mid-scale 128
        check("R1", int'(rd_thr), 128);
        check_all("R1");
    endtask

    task automatic t_proportional;
        int v;
        update(5, 160, 128, 77);      // +32*77/256 -> +9
        read_mb(5, v);
        check("R2", v, 137);
        update(6, 100, 128, 77);      // floor(-8.42) = -9
        read_mb(6, v);
        check("R2", v, 119);
        update(5, 160, 128, 77);      // 137 -> 146
        read_mb(5, v);
        check("R2", v, 146);
        check_all("R5");              // neighbours untouched
    endtask

    task automatic t_clamp;
        int v;
        for (int k = 0; k < 4; k++) update(1, 256, 64, 255);
        read_mb(1, v);
        check("R4", v, 256);
        for (int k = 0; k < 4; k++) update(2, 0, 256, 255);
        read_mb(2, v);
        check("R3", v, 0);
        update(9, 256, 0, 255);       // 128+255 saturates
        read_mb(9, v);
        check("R9", v, 256);
        update(10, 0, 256, 255);      // 128-255 saturates
        read_mb(10, v);
        check("R9", v, 0);
        update(2, 0, 256, 255);       // already at zero, stays
        read_mb(2, v);
        check("R3", v, 0);
    endtask

    task automatic t_idle_equal;
        int v;
        @(negedge clk);
        upd_valid = 1'b0;
        upd_mb = 4'd3; upd_cnt = 9'd256; tgt_cnt = 9'd0; kp_gain = 8'd255;
        repeat (4) @(negedge clk);
        check_all("R7");
        update(3, 192, 192, 255);
        read_mb(3, v);
        check("R8", v, 128);
        update(12, 0, 0, 200);
        read_mb(12, v);
        check("R8", v, 128);
    endtask

    task automatic t_same_cycle;
        int oldv, newv;
        oldv = model[5];
        @(negedge clk);
        rd_mb = 4'd5;
        upd_valid = 1'b1; upd_mb = 4'd5; upd_cnt = 9'd64; tgt_cnt = 9'd192; kp_gain = 8'd128;
        model[5] = step_model(model[5], 64, 192, 128);
        newv = model[5];
        @(negedge clk);
        upd_valid = 1'b0;
        check("R6", int'(rd_thr), oldv);
        @(negedge clk);
        check("R6", int'(rd_thr), newv);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 128;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_proportional();
        t_clamp();
        t_idle_equal();
        t_same_cycle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule